// File: doc/BRIEF.md
# Interrupt Vector Fetch Override

This block sits beside the chip-memory decoder on a 16-bit, 68000-style CPU bus and serves a debug monitor. When the monitor button is pressed, the block arms itself. It then watches the bus for the CPU fetching the non-maskable interrupt vector at the fixed offset $7C. When that fetch appears, the block keeps RAM from being selected and places a hard-wired entry address on its override data output for that read.

The 32-bit entry address $00A0000C comes back as two word reads: $00A0 for the word at $7C and $000C for the word at $7E. When the bus strobe of the low-word read drops, the block disarms. The CPU therefore always lands in the monitor, whatever software has written to the vector location in RAM. Only fetches that cross this bus are visible. A vector table held in memory that the CPU reaches by another path is never trapped.

Top module: `vec_override`

## Requirements
- R1: After reset, `armed` is 0, `ramInhibit` is 0 and `ovrData` is zero.
- R2: A rising edge of `monBtn`, after a synchronizer of `SYNC_STAGES` flops, sets `armed` within `SYNC_STAGES`+2 clocks. Holding the button high does not arm the block again after it disarms.
- R3: While armed, a read (`busValid`=1, `busRead`=1, at least one of `busUds`/`busLds` high) at word address $7C>>1 drives `ramInhibit`=1 and `ovrData`=$00A0 in the same cycle.
- R4: While armed, a read at word address $7E>>1 drives `ramInhibit`=1 and `ovrData`=$000C in the same cycle.
- R5: After a low-word ($7E) override, `ramInhibit` stays high for as long as that access is held. `armed` falls on the clock after `busValid` drops.
- R6: While disarmed, reads at $7C and $7E leave `ramInhibit`=0 and `ovrData`=0.
- R7: Writes (`busRead`=0) to $7C or $7E never raise `ramInhibit` and never change `armed`.
- R8: While armed, reads at any other address leave `ramInhibit`=0 and do not disarm the block.
- R9: A button press while armed has no extra effect. One low-word override still disarms the block.
- R10: An armed access with both data strobes low is not trapped.
- R11: `ovrData` is zero whenever `ramInhibit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| monBtn | input | 1 | Asynchronous monitor button, active high |
| busAddr | input | ADDR_W-1 | CPU word address (byte address bits ADDR_W-1..1) |
| busValid | input | 1 | Address strobe: an access is in progress |
| busRead | input | 1 | 1 = read, 0 = write |
| busUds | input | 1 | Upper byte data strobe |
| busLds | input | 1 | Lower byte data strobe |
| ramInhibit | output | 1 | Blocks the RAM select for this access |
| ovrData | output | DATA_W | Replacement read data |
| armed | output | 1 | Override pending |

## Verification
The bench uses the default parameters: a 24-bit address, a 16-bit data bus, a two-flop synchronizer, vector offset $7C and entry address $00A0000C. With these values, an arm takes only a handful of clocks, so every step of the sequence fits in a short run. The steps are arm, passing writes and stray reads, the high word, a second press while armed, the held low word, the release, and a re-arm attempt with the button still high. Each word can be checked against its fixed literal.

// File: rtl/vec_override_pkg.sv
package vec_override_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_FINISH = 2'd2
  } ovrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic enHigh;
    logic enLow;
  } ovrStrobe_t;

endpackage

// File: rtl/vec_override_ctrl.sv
module vec_override_ctrl
  import vec_override_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       monBtn,
  input  logic       busValid,
  input  logic       busRead,
  input  logic       hitLow,
  output ovrStrobe_t ctlStr,
  output logic       armed
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] syncQ;
  logic              btnPrev;
  logic              btnRise;
  ovrState_e         state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      btnPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_MSB-1:0], monBtn};
      btnPrev <= syncQ[SYNC_MSB];
    end
  end

  assign btnRise = syncQ[SYNC_MSB] & ~btnPrev;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (btnRise)   stateNext = ST_ARMED;
      ST_ARMED:  if (hitLow)    stateNext = ST_FINISH;
      ST_FINISH: if (!busValid) stateNext = ST_IDLE;
      default:                  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign ctlStr.enHigh = (state == ST_ARMED);
  assign ctlStr.enLow  = (state == ST_ARMED) || (state == ST_FINISH);
  assign armed         = (state != ST_IDLE);

  // R2
  arm_from_button_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(btnRise));

  // R5
  release_disarms_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FINISH && !busValid) |=> !armed);

  // R7
  write_keeps_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED && busValid && !busRead) |=> armed);

endmodule

// File: rtl/vec_override_dp.sv
module vec_override_dp
  import vec_override_pkg::*;
#(
  parameter int                  ADDR_W     = 24,
  parameter int                  DATA_W     = 16,
  parameter logic [ADDR_W-1:0]   VEC_OFFSET = 'h7C,
  parameter logic [2*DATA_W-1:0] ENTRY_ADDR = 'h00A0000C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:1] busAddr,
  input  logic              busValid,
  input  logic              busRead,
  input  logic              busUds,
  input  logic              busLds,
  input  ovrStrobe_t        ctlStr,
  output logic              hitLow,
  output logic              ramInhibit,
  output logic [DATA_W-1:0] ovrData
);

  localparam logic [ADDR_W-1:1] HI_WORD  = VEC_OFFSET[ADDR_W-1:1];
  localparam logic [ADDR_W-1:1] LO_WORD  = HI_WORD + 1'b1;
  localparam logic [DATA_W-1:0] HI_VALUE = ENTRY_ADDR[2*DATA_W-1:DATA_W];
  localparam logic [DATA_W-1:0] LO_VALUE = ENTRY_ADDR[DATA_W-1:0];

  logic readCycle;
  logic hitHigh;

  assign readCycle  = busValid & busRead & (busUds | busLds);
  assign hitHigh    = readCycle & ctlStr.enHigh & (busAddr == HI_WORD);
  assign hitLow     = readCycle & ctlStr.enLow  & (busAddr == LO_WORD);
  assign ramInhibit = hitHigh | hitLow;

  always_comb begin
    ovrData = '0;
    if (hitHigh)     ovrData = HI_VALUE;
    else if (hitLow) ovrData = LO_VALUE;
  end

  // R7
  inhibit_only_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramInhibit |-> (busValid && busRead));

  // R11
  data_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ramInhibit |-> (ovrData == '0));

  // R10
  strobe_needed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busUds && !busLds) |-> !ramInhibit);

endmodule

// File: rtl/vec_override.sv
module vec_override
  import vec_override_pkg::*;
#(
  parameter int                  ADDR_W      = 24,
  parameter int                  DATA_W      = 16,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0]   VEC_OFFSET  = 'h7C,
  parameter logic [2*DATA_W-1:0] ENTRY_ADDR  = 'h00A0000C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              monBtn,
  input  logic [ADDR_W-1:1] busAddr,
  input  logic              busValid,
  input  logic              busRead,
  input  logic              busUds,
  input  logic              busLds,
  output logic              ramInhibit,
  output logic [DATA_W-1:0] ovrData,
  output logic              armed
);

  ovrStrobe_t ctlStr;
  logic       hitLow;

  vec_override_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .monBtn(monBtn), .busValid(busValid),
    .busRead(busRead), .hitLow(hitLow), .ctlStr(ctlStr), .armed(armed)
  );

  vec_override_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .VEC_OFFSET(VEC_OFFSET), .ENTRY_ADDR(ENTRY_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busValid(busValid),
    .busRead(busRead), .busUds(busUds), .busLds(busLds), .ctlStr(ctlStr),
    .hitLow(hitLow), .ramInhibit(ramInhibit), .ovrData(ovrData)
  );

endmodule

// File: tb/vec_override_test.sv
module vec_override_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        monBtn = 1'b0;
  logic [23:1] busAddr = '0;
  logic        busValid = 1'b0, busRead = 1'b0, busUds = 1'b0, busLds = 1'b0;
  logic        ramInhibit, armed;
  logic [15:0] ovrData;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  typedef struct {
    logic        chkBus;
    logic        expInh;
    logic [15:0] expData;
    logic        chkArm;
    logic        expArm;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  always #10 clk = ~clk;

  vec_override uut (
    .clk(clk), .rstN(rstN), .monBtn(monBtn), .busAddr(busAddr),
    .busValid(busValid), .busRead(busRead), .busUds(busUds), .busLds(busLds),
    .ramInhibit(ramInhibit), .ovrData(ovrData), .armed(armed)
  );

  // monitor: compares queued expectations 5 ns after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (expQ.size() > 0) begin
        exp_t it;
        it = expQ.pop_front();
        if (it.chkBus) begin
          nChecks++;
          if (ramInhibit !== it.expInh || ovrData !== it.expData) begin
            nFails++;
            $display("FAIL %s: inhibit=%0b data=%h expected inhibit=%0b data=%h",
                     it.tag, ramInhibit, ovrData, it.expInh, it.expData);
          end
        end
        if (it.chkArm) begin
          nChecks++;
          if (armed !== it.expArm) begin
            nFails++;
            $display("FAIL %s: armed=%0b expected armed=%0b", it.tag, armed, it.expArm);
          end
        end
      end
    end
  end

  task automatic pushBus(input logic inh, input logic [15:0] d, input string tag);
    exp_t it;
    it = '{chkBus: 1'b1, expInh: inh, expData: d, chkArm: 1'b0, expArm: 1'b0, tag: tag};
    expQ.push_back(it);
  endtask

  task automatic checkArm(input logic a, input string tag);
    exp_t it;
    @(negedge clk);
    it = '{chkBus: 1'b0, expInh: 1'b0, expData: 16'h0, chkArm: 1'b1, expArm: a, tag: tag};
    expQ.push_back(it);
  endtask

  // one bus access held for two clocks, then released
  task automatic busOp(input logic [23:0] byteAddr, input logic rd,
                       input logic uds, input logic lds,
                       input logic expInh, input logic [15:0] expData,
                       input string tag);
    @(negedge clk);
    busAddr = byteAddr[23:1]; busRead = rd; busUds = uds; busLds = lds;
    busValid = 1'b1;
    pushBus(expInh, expData, tag);
    @(negedge clk);
    pushBus(expInh, expData, {tag, " held"});
    @(negedge clk);
    busValid = 1'b0; busUds = 1'b0; busLds = 1'b0; busRead = 1'b0;
    @(posedge clk);
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    waitClk(3);
    // R1 reset state
    @(negedge clk);
    pushBus(1'b0, 16'h0, "R1 reset bus");
    checkArm(1'b0, "R1 reset armed");
    @(negedge clk); rstN = 1'b1;
    waitClk(2);

    // R6 disarmed reads pass through
    busOp(24'h7C, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0, "R6 read 7C disarmed");
    busOp(24'h7E, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0, "R6 read 7E disarmed");

    // R2 arm on press (held high)
    @(negedge clk); monBtn = 1'b1;
    waitClk(5);
    checkArm(1'b1, "R2 armed after press");

    // R7 writes pass, keep arm
    busOp(24'h7C, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0, "R7 write 7C");
    busOp(24'h7E, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0, "R7 write 7E");
    checkArm(1'b1, "R7 armed after writes");

    // R8 other addresses
    busOp(24'h80, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0, "R8 read 80");
    busOp(24'h7A, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0, "R8 read 7A");
    checkArm(1'b1, "R8 armed after other reads");

    // R10 no data strobes
    busOp(24'h7E, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, "R10 no strobes 7E");
    checkArm(1'b1, "R10 armed kept");

    // R3 high word, single strobe
    busOp(24'h7C, 1'b1, 1'b1, 1'b0, 1'b1, 16'h00A0, "R3 high word");
    checkArm(1'b1, "R3 armed after high word");

    // R9 second press while armed
    @(negedge clk); monBtn = 1'b0;
    waitClk(4);
    @(negedge clk); monBtn = 1'b1;
    waitClk(5);
    checkArm(1'b1, "R9 armed after second press");

    // R4 / R5 low word, held, then disarm
    busOp(24'h7E, 1'b1, 1'b0, 1'b1, 1'b1, 16'h000C, "R4 R5 low word");
    checkArm(1'b0, "R5 disarmed after release");
    checkArm(1'b0, "R9 single disarm");

    // R2 held button does not re-arm
    waitClk(5);
    checkArm(1'b0, "R2 no re-arm while held");

    // R6 after disarm
    busOp(24'h7C, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0, "R6 read 7C after disarm");

    // re-arm, low word alone, R11 idle data
    @(negedge clk); monBtn = 1'b0;
    waitClk(4);
    @(negedge clk); monBtn = 1'b1;
    waitClk(5);
    checkArm(1'b1, "R2 re-armed");
    busOp(24'h7E, 1'b1, 1'b1, 1'b1, 1'b1, 16'h000C, "R4 low word direct");
    checkArm(1'b0, "R5 disarmed again");
    @(negedge clk);
    pushBus(1'b0, 16'h0, "R11 idle data zero");

    waitClk(3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule